// File: doc/BRIEF.md
# Quasi-bidirectional port pin controller

This block keeps the output latch of an 8-bit general-purpose I/O port. For each pin it produces the enables of a quasi-bidirectional output stage: one strong pull-down and three pull-ups (weak, medium and strong). Each pull-up follows its own rule. The weak pull-up holds a released pin high. The medium pull-up supplies the main high-level current, but only while the pin actually reads high. The strong pull-up gives a short boost when a latch bit rises from 0 to 1.

A pin works as an input once its latch bit holds 1. An external device can then pull it low against the weak pull-up, and software reads the synchronized pin level. A read-modify-write access returns the latch contents instead of the pin levels. A single global control bit suppresses the weak pull-up on every pin. Pad currents and thresholds are outside the model. Only the enable sequencing is built here.

Top module: `qb_port_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving it, every latch bit is 1, no strong pull-up is active, no pull-down is active, and both synchronizer stages hold 1, so the pin readback is 0xFF.
- R2: A write strobe loads `wr_data` into the latch at the clock edge. Without a strobe the latch holds its value.
- R3: The pull-down enable of a pin is active exactly when its latch bit is 0.
- R4: The weak pull-up enable of a pin is active when its latch bit is 1 and `wpu_off` is 0. When `wpu_off` is 1 it is off on all pins.
- R5: The medium pull-up enable of a pin is active when its latch bit is 1 and its synchronized pin level is 1.
- R6: When a write changes a latch bit from 0 to 1, that pin's strong pull-up is active for exactly the two cycles after the write edge, then turns off.
- R7: The strong pull-up never turns on for any other event: not for a write that leaves a bit at 1, not for a write that keeps it at 0, and not for reset.
- R8: A write of 0 to a bit during its strong pulse ends the pulse at that edge.
- R9: With `rmw_sel` = 0 the readback is the pin level after two synchronizer flops. With `rmw_sel` = 1 it is the latch contents.
- R10: For each pin the pull-down enable is never active in the same cycle as any pull-up enable.
- R11: A pin whose latch bit is 1 and that is pulled low from outside reads 0 and loses its medium pull-up two cycles later, while its weak pull-up stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Data written to the latch |
| rmw_sel | input | 1 | Readback source: 0 pins, 1 latch |
| pin_in | input | WIDTH | Raw pin levels |
| wpu_off | input | 1 | Global weak pull-up suppress |
| pd_en | output | WIDTH | Strong pull-down enables |
| wk_en | output | WIDTH | Weak pull-up enables |
| md_en | output | WIDTH | Medium pull-up enables |
| st_en | output | WIDTH | Strong pull-up enables |
| latch_q | output | WIDTH | Latch contents |
| rd_data | output | WIDTH | Readback value |

## Verification
On every cycle the assertions check that the drive enables never overlap and that the weak and medium pull-ups stay off on a pin whose latch bit is 0. They also check that a write lands in the latch, that a strong pulse starts only after a 0-to-1 latch change, that it lasts no more than two cycles, and that it ends when a 0 is written. The exact two-cycle pulse length, the two-cycle delay of the synchronizer in readback and in the medium pull-up, and the reset state can only be seen in the bench's scenarios. The bench compares every output against a cycle model while sweeping all latch values, pin patterns and control settings.

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rmw_sel,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             wpu_off,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] wk_en,
  output logic [WIDTH-1:0] md_en,
  output logic [WIDTH-1:0] st_en,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] rd_data
);
  localparam int BOOST = 2;
  localparam int CW    = $clog2(BOOST + 1);

  logic [WIDTH-1:0] sync_a, sync_b;
  logic [WIDTH-1:0] boost_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      sync_a  <= '1;
      sync_b  <= '1;
    end else begin
      if (wr_en) latch_q <= wr_data;
      sync_a <= pin_in;
      sync_b <= sync_a;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cnt <= '0;
      else if (wr_en && wr_data[i] && !latch_q[i]) cnt <= CW'(BOOST);
      else if (wr_en && !wr_data[i])              cnt <= '0;
      else if (cnt != '0)                         cnt <= cnt - 1'b1;
    end
    assign boost_on[i] = (cnt != '0);
  end

  assign pd_en   = ~latch_q;
  assign wk_en   = latch_q & {WIDTH{~wpu_off}};
  assign md_en   = latch_q & sync_b;
  assign st_en   = latch_q & boost_on;
  assign rd_data = rmw_sel ? latch_q : sync_b;
endmodule

module qb_port_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             wpu_off,
  input logic [WIDTH-1:0] pd_en,
  input logic [WIDTH-1:0] wk_en,
  input logic [WIDTH-1:0] md_en,
  input logic [WIDTH-1:0] st_en,
  input logic [WIDTH-1:0] latch_q
);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> latch_q == $past(wr_data));

  a_r4_weak_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    wpu_off |-> wk_en == '0);

  a_r5_medium_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (md_en & ~latch_q) == '0);

  a_r6_pulse_starts_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en & ~$past(st_en) & $past(latch_q)) == '0);

  a_r6_pulse_max_two: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en & $past(st_en) & $past(st_en, 2)) == '0);

  a_r8_zero_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (st_en & ~$past(wr_data)) == '0);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en & (wk_en | md_en | st_en)) == '0);
endmodule

bind qb_port_ctrl qb_port_ctrl_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wpu_off(wpu_off),
  .pd_en(pd_en), .wk_en(wk_en), .md_en(md_en), .st_en(st_en), .latch_q(latch_q)
);

// File: tb/qb_port_ctrl_tb.sv
module qb_port_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rmw_sel = 1'b0;
  logic [7:0] pin_in = 8'hFF;
  logic       wpu_off = 1'b0;
  logic [7:0] pd_en, wk_en, md_en, st_en, latch_q, rd_data;

  int vectors = 0;
  int fails = 0;
  string st_tag = "R6";

  logic [7:0] m_l, m_s1, m_s2;
  int m_cnt [8];

  always #4 clk = ~clk;

  qb_port_ctrl #(.WIDTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rmw_sel(rmw_sel),
    .pin_in(pin_in), .wpu_off(wpu_off), .pd_en(pd_en), .wk_en(wk_en), .md_en(md_en),
    .st_en(st_en), .latch_q(latch_q), .rd_data(rd_data)
  );

  task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [7:0] st_exp;
    for (int i = 0; i < 8; i++) st_exp[i] = (m_cnt[i] != 0);
    cmp("R2", "latch_q", latch_q, m_l);
    cmp("R3", "pd_en", pd_en, ~m_l);
    cmp("R4", "wk_en", wk_en, wpu_off ? 8'h00 : m_l);
    cmp("R5/R11", "md_en", md_en, m_l & m_s2);
    cmp(st_tag, "st_en", st_en, st_exp);
    cmp("R9", "rd_data", rd_data, rmw_sel ? m_l : m_s2);
    cmp("R10", "overlap", pd_en & (wk_en | md_en | st_en), 8'h00);
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic [7:0] p,
                      input logic rs, input logic off);
    wr_en = w; wr_data = d; pin_in = p; rmw_sel = rs; wpu_off = off;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      if (w && d[i] && !m_l[i])   m_cnt[i] = 2;
      else if (w && !d[i])        m_cnt[i] = 0;
      else if (m_cnt[i] > 0)      m_cnt[i] = m_cnt[i] - 1;
    end
    if (w) m_l = d;
    m_s2 = m_s1;
    m_s1 = p;
    @(negedge clk);
    wr_en = 1'b0;
    check_all();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    m_l = 8'hFF; m_s1 = 8'hFF; m_s2 = 8'hFF;
    for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    cmp("R1", "latch_q in reset", latch_q, 8'hFF);
    cmp("R1", "st_en in reset", st_en, 8'h00);
    cmp("R1", "pd_en in reset", pd_en, 8'h00);
    cmp("R1", "rd_data in reset", rd_data, 8'hFF);
    rst_n = 1'b1;
    st_tag = "R7";
    step(1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
    step(1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0);

    // R6 sweep over all latch values, pin patterns and control bits
    st_tag = "R6";
    for (int v = 0; v < 256; v++) begin
      logic [7:0] a = 8'(v);
      step(1'b1, a, 8'(v * 37 + 11), a[0], a[1]);
      step(1'b0, 8'h00, 8'(v * 53 + 7), a[2], a[3]);
      step(1'b1, ~a, 8'(v * 91 + 3), a[4], a[5]);
      step(1'b0, 8'h00, 8'(v * 29 + 1), a[6], a[7]);
    end

    // R8: zero written mid-pulse
    st_tag = "R8";
    step(1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);
    step(1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0);
    step(1'b1, 8'h0F, 8'hFF, 1'b1, 1'b0);
    step(1'b0, 8'h00, 8'hFF, 1'b1, 1'b0);
    step(1'b0, 8'h00, 8'hFF, 1'b1, 1'b0);

    // R7: rewrite of 1 over 1, mid-pulse and after
    st_tag = "R7";
    step(1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0);
    step(1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0);
    step(1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
    step(1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0);
    step(1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);
    step(1'b1, 8'h00, 8'hFF, 1'b0, 1'b0);

    // R11: released pins pulled low from outside
    st_tag = "R6";
    step(1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b0, 8'h00, 8'h3C, 1'b0, 1'b0);
    cmp("R11", "md_en after pull-low", md_en, 8'h3C);
    cmp("R11", "rd_data after pull-low", rd_data, 8'h3C);
    cmp("R11", "wk_en after pull-low", wk_en, 8'hFF);
    for (int k = 0; k < 3; k++) step(1'b0, 8'h00, 8'hFF, 1'b0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule